// File: doc/BRIEF.md
# Interrupt on Terminal Count Timer

This block is a single 16-bit down-counting timer channel that raises its output once a programmed count has run out. A host sets it up with a control write, which selects how count bytes are taken and forces the output low. It then writes a count, as one byte or as two. The counter advances on counter-clock pulses, which reach the block as a one-cycle enable in the system clock domain. A level input, the gate, pauses and resumes the decrement.

A count written by the host waits in a holding register. It is moved into the counting element on the next counter-clock pulse, and that pulse does not decrement. For a count of N, the output therefore rises on the (N+1)th pulse after the write. After the count reaches zero the output stays high and the counter keeps wrapping downward. It stays high until the host writes a new count or a new control word. In two-byte format, the first byte freezes the counter and drops the output at once. The second byte completes the value, and that value is then loaded on the next pulse.

Top module: `tc_int_timer`

## Requirements
- R1: After reset `out` is 0, and counter-clock pulses leave it at 0 until a control word and a count have been written.
- R2: A control write whose format field is not 00 forces `out` to 0 on the next cycle and cancels any pending or running count, so later pulses leave `out` at 0 until a count is written.
- R3: A control write with format field 00 has no effect: `out` and the selected byte format are unchanged.
- R4: Format 01 takes each count write as the low byte, with the high byte zero. Format 10 takes it as the high byte, with the low byte zero.
- R5: The first counter-clock pulse after a complete count N is written loads the count without decrementing, so `out` is still 0 after N pulses and becomes 1 after N+1 pulses.
- R6: While `gate` is 0 the counter neither decrements nor raises `out`, but a pending load still occurs. Once `gate` is 1, `out` rises after N further pulses.
- R7: Once high, `out` stays at 1 through further pulses, while the counter wraps past zero, until a count or a non-00 control word is written.
- R8: A count written while counting forces `out` to 0 on the next cycle. The next pulse loads the new value, and `out` rises N+1 pulses after the write.
- R9: In format 11 the first write is the low byte. It forces `out` to 0 and halts counting, and pulses have no effect until the second write. The second write is the high byte, and the combined count loads on the next pulse.
- R10: A count of zero behaves as 65536: `out` rises on the 65537th pulse after the write.
- R11: A counter-clock pulse in the same cycle as a count write, or as a non-00 control write, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable marking a completed counter-clock pulse |
| gate | input | 1 | Level enable for decrementing |
| wr_ctrl | input | 1 | Control word write strobe |
| ctrl_fmt | input | 2 | Byte format carried by the control write (00 none, 01 low, 10 high, 11 low then high) |
| wr_cnt | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte |
| out | output | 1 | Terminal count output |

## Verification
The assertions assume that each strobe and `tick` lasts one system clock cycle per event. They also assume that `gate` is a clean, synchronous level. Under these assumptions, a rise of `out` can only follow a pulse taken with the gate high and no count write. The stimulus changes every input on the falling clock edge and issues writes as single-cycle strobes. Pulses are kept apart from writes, except in the one scenario that deliberately overlaps them to exercise R11.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_LOHI = 2'b11
    } fmt_e;
endpackage

// File: rtl/tc_byte_seq.sv
module tc_byte_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [1:0]       ctrl_fmt,
    input  logic             wr_cnt,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W-1:0] cr,
    output logic             load_req,
    output logic             stop_req
);
    import tc_pkg::*;
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        fmt_e             fmt;
        logic             hi_next;
        logic [CNT_W-1:0] cr;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        load_req = 1'b0;
        stop_req = 1'b0;
        if (wr_ctrl && fmt_e'(ctrl_fmt) != FMT_NONE) begin
            st_d.fmt     = fmt_e'(ctrl_fmt);
            st_d.hi_next = 1'b0;
            stop_req     = 1'b1;
        end else if (wr_cnt) begin
            case (st_q.fmt)
                FMT_LO: begin
                    st_d.cr  = {{HALF{1'b0}}, wr_data};
                    load_req = 1'b1;
                end
                FMT_HI: begin
                    st_d.cr  = {wr_data, {HALF{1'b0}}};
                    load_req = 1'b1;
                end
                FMT_LOHI: begin
                    if (!st_q.hi_next) begin
                        st_d.cr[HALF-1:0] = wr_data;
                        st_d.hi_next      = 1'b1;
                        stop_req          = 1'b1;
                    end else begin
                        st_d.cr[CNT_W-1:HALF] = wr_data;
                        st_d.hi_next          = 1'b0;
                        load_req              = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{fmt: FMT_NONE, hi_next: 1'b0, cr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cr = st_q.cr;
endmodule

// File: rtl/tc_count_elem.sv
module tc_count_elem #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] cr,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] ce;
        logic             pend;
        logic             armed;
    } elem_t;

    elem_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        zero_hit = 1'b0;
        if (stop_req) begin
            st_d.pend  = 1'b0;
            st_d.armed = 1'b0;
        end else if (load_req) begin
            st_d.pend = 1'b1;
        end else if (tick) begin
            if (st_q.pend) begin
                st_d.ce    = cr;
                st_d.pend  = 1'b0;
                st_d.armed = 1'b1;
            end else if (st_q.armed && gate) begin
                st_d.ce  = st_q.ce - ONE;
                zero_hit = (st_q.ce == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ce: '0, pend: 1'b0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tc_int_timer.sv
module tc_int_timer #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               gate,
    input  logic               wr_ctrl,
    input  logic [1:0]         ctrl_fmt,
    input  logic               wr_cnt,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic               out
);
    typedef struct packed {
        logic out;
    } top_t;

    top_t             st_d, st_q;
    logic [CNT_W-1:0] cr;
    logic             load_req;
    logic             stop_req;
    logic             zero_hit;

    tc_byte_seq #(.CNT_W(CNT_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .ctrl_fmt (ctrl_fmt),
        .wr_cnt   (wr_cnt),
        .wr_data  (wr_data),
        .cr       (cr),
        .load_req (load_req),
        .stop_req (stop_req)
    );

    tc_count_elem #(.CNT_W(CNT_W)) i_elem (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .load_req (load_req),
        .stop_req (stop_req),
        .cr       (cr),
        .zero_hit (zero_hit)
    );

    always_comb begin
        st_d = st_q;
        if (load_req || stop_req) begin
            st_d.out = 1'b0;
        end else if (zero_hit) begin
            st_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.out;
endmodule

// File: rtl/tc_int_timer_chk.sv
module tc_int_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               gate,
    input logic               wr_ctrl,
    input logic [1:0]         ctrl_fmt,
    input logic               wr_cnt,
    input logic [CNT_W/2-1:0] wr_data,
    input logic               out
);
    logic ctrl_real;
    assign ctrl_real = wr_ctrl && (ctrl_fmt != 2'b00);

    assert_ctrl_clears_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_real |=> !out);

    assert_write_clears_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !ctrl_real) |=> !out);

    assert_rise_needs_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out) |-> $past(tick && gate && !wr_cnt && !ctrl_real));

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out && !wr_cnt && !ctrl_real) |=> out);

    assert_fmt_none_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_fmt == 2'b00 && !wr_cnt && !tick) |=> $stable(out));
endmodule

bind tc_int_timer tc_int_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gate     (gate),
    .wr_ctrl  (wr_ctrl),
    .ctrl_fmt (ctrl_fmt),
    .wr_cnt   (wr_cnt),
    .wr_data  (wr_data),
    .out      (out)
);

// File: tb/test_tc_int_timer.sv
`timescale 1ns/1ps
module test_tc_int_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       gate = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [1:0] ctrl_fmt = 2'b00;
    logic       wr_cnt = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tc_int_timer i_tc_int_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .wr_ctrl(wr_ctrl), .ctrl_fmt(ctrl_fmt), .wr_cnt(wr_cnt),
        .wr_data(wr_data), .out(out)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (out !== exp) begin
            errors++;
            $display("FAIL %s out actual=%b expected=%b", req, out, exp);
        end
    endtask

    task automatic ctrl(input logic [1:0] f);
        @(negedge clk); wr_ctrl = 1'b1; ctrl_fmt = f;
        @(negedge clk); wr_ctrl = 1'b0; ctrl_fmt = 2'b00;
    endtask

    task automatic wr(input logic [7:0] d, input logic with_tick = 1'b0);
        @(negedge clk); wr_cnt = 1'b1; wr_data = d; tick = with_tick;
        @(negedge clk); wr_cnt = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk); tick = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0);
        gate = 1'b1;
        ticks(10);
        check("R1 no count written", 1'b0);
    endtask

    task automatic t_basic_lo();
        ctrl(2'b01);
        check("R2 ctrl write", 1'b0);
        wr(8'd4);
        ticks(4);
        check("R5 after N pulses", 1'b0);
        ticks(1);
        check("R5 after N+1 pulses", 1'b1);
        ticks(10);
        check("R7 stays high past zero", 1'b1);
    endtask

    task automatic t_fmt_none();
        ctrl(2'b00);
        check("R3 fmt 00 keeps out", 1'b1);
        wr(8'd2);
        check("R3 count write after fmt 00", 1'b0);
        ticks(2);
        check("R3 low format kept, N pulses", 1'b0);
        ticks(1);
        check("R3 low format kept, N+1 pulses", 1'b1);
    endtask

    task automatic t_ctrl_cancel();
        ctrl(2'b01);
        check("R2 ctrl clears high out", 1'b0);
        ticks(20);
        check("R2 no count after ctrl", 1'b0);
    endtask

    task automatic t_gate();
        gate = 1'b0;
        ctrl(2'b01);
        wr(8'd3);
        ticks(1);
        ticks(5);
        check("R6 gate low holds", 1'b0);
        gate = 1'b1;
        ticks(2);
        check("R6 after N-1 gated pulses", 1'b0);
        ticks(1);
        check("R6 after N gated pulses", 1'b1);
    endtask

    task automatic t_rewrite();
        wr(8'd10);
        check("R7 count write clears out", 1'b0);
        ticks(4);
        wr(8'd2);
        check("R8 rewrite keeps low", 1'b0);
        ticks(2);
        check("R8 new count N pulses", 1'b0);
        ticks(1);
        check("R8 new count N+1 pulses", 1'b1);
    endtask

    task automatic t_hi_only();
        ctrl(2'b10);
        wr(8'd1);
        ticks(256);
        check("R4 high byte 256 pulses", 1'b0);
        ticks(1);
        check("R4 high byte 257 pulses", 1'b1);
    endtask

    task automatic t_two_byte();
        ctrl(2'b11);
        wr(8'd2);
        wr(8'd1);
        ticks(258);
        check("R9 two-byte 258 pulses", 1'b0);
        ticks(1);
        check("R9 two-byte 259 pulses", 1'b1);
        wr(8'd3);
        check("R9 first byte drops out", 1'b0);
        ticks(300);
        check("R9 halted after first byte", 1'b0);
        wr(8'd0);
        ticks(3);
        check("R9 second byte N pulses", 1'b0);
        ticks(1);
        check("R9 second byte N+1 pulses", 1'b1);
    endtask

    task automatic t_overlap();
        ctrl(2'b01);
        wr(8'd2, 1'b1);
        ticks(2);
        check("R11 overlapping pulse ignored, N pulses", 1'b0);
        ticks(1);
        check("R11 N+1 pulses", 1'b1);
    endtask

    task automatic t_zero();
        ctrl(2'b01);
        wr(8'd0);
        ticks(65536);
        check("R10 zero count 65536 pulses", 1'b0);
        ticks(1);
        check("R10 zero count 65537 pulses", 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_lo();
        t_fmt_none();
        t_ctrl_cancel();
        t_gate();
        t_rewrite();
        t_hi_only();
        t_two_byte();
        t_overlap();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule